// File: doc/BRIEF.md
# Byte-Wide Flash Array Model with Protocol Checker

This block stands in for a small byte-organised flash array whose control strobes are driven raw, without a sequencing controller in front of it. On every clock it turns the individual enable and operation lines into one of four operations: read, byte program, page erase or mass erase. It then applies that operation to a parameterised storage array, which has a main region and a separate information region. Time is counted in clock cycles. The high-voltage budget is converted from microseconds using a clock-rate parameter.

Alongside the storage behaviour, the block watches the strobe protocol. It raises sticky error flags for four cases: an operation attempted without the test-mode line, a strobe pattern that matches no known state, a byte programmed more often than allowed between erases, and a row whose accumulated program-and-store time exceeds its budget. It is meant for simulation of programming sequences and for emulation builds where a real array is not available.

Top module: `flash_macro_model`

## Requirements
- R1: A 10-bit row address and a 6-bit column address select one byte. Each row holds 64 bytes. Main rows alias modulo MAIN_ROWS, and information rows alias modulo INFO_ROWS. After reset every byte reads 0xFF, `rdata` is 0x00 and all four flags are 0.
- R2: Read is decoded when xen, yen, sen and oen are high, prg, ers, mass and store are low, and tmode is high. The addressed byte appears on `rdata` after the next clock edge. `rdata` holds its value on every cycle that is not a read.
- R3: A byte program is decoded when xen, yen, prg and store are high and sen, oen, ers and mass are low. A byte program happens once on entry into that pattern: it stores the old byte AND `wdata`. The pattern xen=1, prg=1, store=0 or 1, with every other strobe low, is a legal program hold and changes nothing.
- R4: Page erase is decoded when xen, ers and store are high and all other strobes are low. It sets every byte of the addressed row to 0xFF, and clears that row's program counts and high-voltage time. The pattern xen=1, ers=1, with mass either value and all others low, is a legal erase setup.
- R5: Mass erase uses the page erase pattern with mass high. With area_sel low it erases every main row only. With area_sel high it erases both the main and the information rows.
- R6: For read, program and page erase, area_sel high targets the information region and area_sel low targets the main region.
- R7: If xen or yen is high while tmode is low, nothing is changed and `err_tmode` becomes 1.
- R8: If xen or yen is high with tmode high and the strobes match none of the patterns in R2 to R5, nothing is changed and `err_illegal` becomes 1.
- R9: A byte may be programmed at most PROG_LIMIT (2) times between erases. A further attempt leaves the byte unchanged and sets `err_overprog`.
- R10: Each row counts the clock cycles in which prg and store are both high while the row is addressed. The budget is CLK_KHZ*HV_US/1000 cycles. The first cycle beyond the budget sets `err_hv`.
- R11: All four error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_addr | input | 10 | Row select (upper address bits) |
| col_addr | input | 6 | Byte within row |
| wdata | input | 8 | Program data |
| xen | input | 1 | Row enable |
| yen | input | 1 | Column enable |
| sen | input | 1 | Sense enable |
| oen | input | 1 | Output enable |
| prg | input | 1 | Program strobe |
| ers | input | 1 | Erase strobe |
| mass | input | 1 | Mass-erase select |
| store | input | 1 | Non-volatile store strobe |
| tmode | input | 1 | Test-mode line, must be high for any operation |
| area_sel | input | 1 | Information region select |
| rdata | output | 8 | Registered read data |
| err_tmode | output | 1 | Sticky: operation attempted with tmode low |
| err_illegal | output | 1 | Sticky: unrecognised strobe pattern |
| err_overprog | output | 1 | Sticky: byte programmed too often |
| err_hv | output | 1 | Sticky: row high-voltage budget exceeded |

## Verification
The hardest condition to reach is the high-voltage overrun just at the boundary. It needs a row to sit in the program-hold state for exactly the budget and then one cycle more. It also has to be shown that a page erase in between restarts the count.

The bench shrinks the clock-rate parameter so that the budget is 120 cycles. It holds program and store on one row for 120 cycles and checks that no flag is set, then holds for one cycle more and checks that the flag is set. A second pass splits 200 cycles around a page erase and expects the flag only after 121 cycles following the erase.

// File: rtl/flash_macro_pkg.sv
package flash_macro_pkg;

    localparam int ROW_W     = 10;
    localparam int COL_W     = 6;
    localparam int DATA_W    = 8;
    localparam int ROW_BYTES = 1 << COL_W;

    typedef struct packed {
        logic xe;
        logic ye;
        logic se;
        logic oe;
        logic pg;
        logic er;
        logic ms;
        logic st;
    } strobe_t;

    typedef enum logic [3:0] {
        FM_IDLE,
        FM_READ,
        FM_PROG,
        FM_PHOLD,
        FM_ESETUP,
        FM_PERASE,
        FM_MERASE,
        FM_BADTM,
        FM_ILLEGAL
    } fmode_e;

    // Strobe order in the match patterns: xe ye se oe pg er ms st
    function automatic fmode_e decode_mode(strobe_t s, logic tm);
        fmode_e m;
        if (!(s.xe || s.ye))
            m = FM_IDLE;
        else if (!tm)
            m = FM_BADTM;
        else begin
            case (s)
                8'b1111_0000: m = FM_READ;
                8'b1100_1001: m = FM_PROG;
                8'b1000_1000,
                8'b1000_1001: m = FM_PHOLD;
                8'b1000_0100,
                8'b1000_0110: m = FM_ESETUP;
                8'b1000_0101: m = FM_PERASE;
                8'b1000_0111: m = FM_MERASE;
                default:      m = FM_ILLEGAL;
            endcase
        end
        return m;
    endfunction

    function automatic int phys_row(logic [ROW_W-1:0] r, logic info,
                                    int main_rows, int info_rows);
        return info ? main_rows + (int'(r) % info_rows) : int'(r) % main_rows;
    endfunction

endpackage

// File: rtl/flash_mode_decode.sv
module flash_mode_decode
    import flash_macro_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobes,
    input  logic    tmode,
    output fmode_e  mode,
    output logic    prog_evt,
    output logic    perase_evt,
    output logic    merase_evt,
    output logic    hv_on
);
    fmode_e prev_q;

    always_comb begin
        mode       = decode_mode(strobes, tmode);
        prog_evt   = (mode == FM_PROG)   && (prev_q != FM_PROG);
        perase_evt = (mode == FM_PERASE) && (prev_q != FM_PERASE);
        merase_evt = (mode == FM_MERASE) && (prev_q != FM_MERASE);
        hv_on      = ((mode == FM_PROG) || (mode == FM_PHOLD)) && strobes.st;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= FM_IDLE;
        else     prev_q <= mode;
    end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_macro_pkg::*;
#(
    parameter int MAIN_ROWS  = 4,
    parameter int NPHYS      = 6,
    parameter int PROG_LIMIT = 2,
    localparam int PR_W      = $clog2(NPHYS),
    localparam int NBYTES    = NPHYS * ROW_BYTES,
    localparam int MAIN_B    = MAIN_ROWS * ROW_BYTES,
    localparam int CNT_W     = $clog2(PROG_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              prog_evt,
    input  logic              perase_evt,
    input  logic              merase_evt,
    input  logic              merase_info,
    input  logic [PR_W-1:0]   prow,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              overprog
);
    logic [DATA_W-1:0] mem [NBYTES];
    logic [CNT_W-1:0]  pcnt [NBYTES];
    int                addr;
    int                rbase;
    logic              at_limit;

    always_comb begin
        rbase    = int'(prow) * ROW_BYTES;
        addr     = rbase + int'(col);
        at_limit = pcnt[addr] >= CNT_W'(PROG_LIMIT);
        overprog = prog_evt && at_limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) begin
                mem[i]  <= '1;
                pcnt[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (rd_en) rdata <= mem[addr];
            if (prog_evt && !at_limit) begin
                mem[addr]  <= mem[addr] & wdata;
                pcnt[addr] <= CNT_W'(pcnt[addr] + 1'b1);
            end
            if (perase_evt) begin
                for (int b = 0; b < ROW_BYTES; b++) begin
                    mem[rbase + b]  <= '1;
                    pcnt[rbase + b] <= '0;
                end
            end
            if (merase_evt) begin
                for (int i = 0; i < NBYTES; i++) begin
                    if (i < MAIN_B || merase_info) begin
                        mem[i]  <= '1;
                        pcnt[i] <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/flash_hv_meter.sv
module flash_hv_meter #(
    parameter int MAIN_ROWS = 4,
    parameter int NPHYS     = 6,
    parameter int HV_LIMIT  = 1200000,
    localparam int PR_W     = $clog2(NPHYS),
    localparam int HV_W     = $clog2(HV_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hv_on,
    input  logic [PR_W-1:0] prow,
    input  logic            perase_evt,
    input  logic            merase_evt,
    input  logic            merase_info,
    output logic            over
);
    logic [HV_W-1:0] acc [NPHYS];
    logic            full;

    always_comb begin
        full = acc[prow] == HV_W'(HV_LIMIT);
        over = hv_on && full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NPHYS; r++) acc[r] <= '0;
        end else begin
            if (hv_on && !full) acc[prow] <= HV_W'(acc[prow] + 1'b1);
            if (perase_evt) acc[prow] <= '0;
            if (merase_evt) begin
                for (int r = 0; r < NPHYS; r++)
                    if (r < MAIN_ROWS || merase_info) acc[r] <= '0;
            end
        end
    end
endmodule

// File: rtl/flash_macro_model.sv
module flash_macro_model
    import flash_macro_pkg::*;
#(
    parameter int MAIN_ROWS  = 4,
    parameter int INFO_ROWS  = 2,
    parameter int PROG_LIMIT = 2,
    parameter int CLK_KHZ    = 100000,
    parameter int HV_US      = 12000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xen,
    input  logic              yen,
    input  logic              sen,
    input  logic              oen,
    input  logic              prg,
    input  logic              ers,
    input  logic              mass,
    input  logic              store,
    input  logic              tmode,
    input  logic              area_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              err_tmode,
    output logic              err_illegal,
    output logic              err_overprog,
    output logic              err_hv
);
    localparam int NPHYS    = MAIN_ROWS + INFO_ROWS;
    localparam int PR_W     = $clog2(NPHYS);
    localparam int HV_LIMIT = CLK_KHZ * HV_US / 1000;

    strobe_t         strobes;
    fmode_e          mode;
    logic            prog_evt, perase_evt, merase_evt, hv_on;
    logic [PR_W-1:0] prow;
    logic            overprog, hv_over;

    always_comb begin
        strobes = '{xe: xen, ye: yen, se: sen, oe: oen,
                    pg: prg, er: ers, ms: mass, st: store};
        prow    = PR_W'(phys_row(row_addr, area_sel, MAIN_ROWS, INFO_ROWS));
    end

    flash_mode_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .strobes    (strobes),
        .tmode      (tmode),
        .mode       (mode),
        .prog_evt   (prog_evt),
        .perase_evt (perase_evt),
        .merase_evt (merase_evt),
        .hv_on      (hv_on)
    );

    flash_cell_array #(
        .MAIN_ROWS  (MAIN_ROWS),
        .NPHYS      (NPHYS),
        .PROG_LIMIT (PROG_LIMIT)
    ) u_array (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (mode == FM_READ),
        .prog_evt    (prog_evt),
        .perase_evt  (perase_evt),
        .merase_evt  (merase_evt),
        .merase_info (area_sel),
        .prow        (prow),
        .col         (col_addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .overprog    (overprog)
    );

    flash_hv_meter #(
        .MAIN_ROWS (MAIN_ROWS),
        .NPHYS     (NPHYS),
        .HV_LIMIT  (HV_LIMIT)
    ) u_hv (
        .clk         (clk),
        .rst         (rst),
        .hv_on       (hv_on),
        .prow        (prow),
        .perase_evt  (perase_evt),
        .merase_evt  (merase_evt),
        .merase_info (area_sel),
        .over        (hv_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_tmode    <= 1'b0;
            err_illegal  <= 1'b0;
            err_overprog <= 1'b0;
            err_hv       <= 1'b0;
        end else begin
            if (mode == FM_BADTM)   err_tmode    <= 1'b1;
            if (mode == FM_ILLEGAL) err_illegal  <= 1'b1;
            if (overprog)           err_overprog <= 1'b1;
            if (hv_over)            err_hv       <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_macro_model_chk.sv
module flash_macro_model_chk (
    input logic       clk,
    input logic       rst,
    input logic       xen,
    input logic       yen,
    input logic       sen,
    input logic       oen,
    input logic       prg,
    input logic       ers,
    input logic       store,
    input logic       tmode,
    input logic [7:0] rdata,
    input logic       err_tmode,
    input logic       err_illegal,
    input logic       err_overprog,
    input logic       err_hv
);
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(xen && yen && sen && oen && tmode) |=> $stable(rdata)); // R2
    AST_TMODE_FLAG: assert property (@(posedge clk) disable iff (rst)
        ((xen || yen) && !tmode) |=> err_tmode); // R7
    AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (xen && tmode && prg && ers) |=> err_illegal); // R8
    AST_OVERPROG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overprog) |-> $past(prg && yen && store)); // R9
    AST_HV_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_hv) |-> $past(prg && store)); // R10
    AST_STICKY_TMODE: assert property (@(posedge clk) disable iff (rst)
        err_tmode |=> err_tmode); // R11
    AST_STICKY_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        err_illegal |=> err_illegal); // R11
    AST_STICKY_OVERPROG: assert property (@(posedge clk) disable iff (rst)
        err_overprog |=> err_overprog); // R11
    AST_STICKY_HV: assert property (@(posedge clk) disable iff (rst)
        err_hv |=> err_hv); // R11
endmodule

bind flash_macro_model flash_macro_model_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .xen          (xen),
    .yen          (yen),
    .sen          (sen),
    .oen          (oen),
    .prg          (prg),
    .ers          (ers),
    .store        (store),
    .tmode        (tmode),
    .rdata        (rdata),
    .err_tmode    (err_tmode),
    .err_illegal  (err_illegal),
    .err_overprog (err_overprog),
    .err_hv       (err_hv)
);

// File: tb/flash_macro_model_tb.sv
module flash_macro_model_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] row_addr;
    logic [5:0] col_addr;
    logic [7:0] wdata;
    logic       xen, yen, sen, oen, prg, ers, mass, store, tmode, area_sel;
    logic [7:0] rdata;
    logic       err_tmode, err_illegal, err_overprog, err_hv;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_macro_model #(
        .MAIN_ROWS (4),
        .INFO_ROWS (2),
        .PROG_LIMIT(2),
        .CLK_KHZ   (10),
        .HV_US     (12000)
    ) u_dut (
        .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
        .wdata(wdata), .xen(xen), .yen(yen), .sen(sen), .oen(oen),
        .prg(prg), .ers(ers), .mass(mass), .store(store), .tmode(tmode),
        .area_sel(area_sel), .rdata(rdata), .err_tmode(err_tmode),
        .err_illegal(err_illegal), .err_overprog(err_overprog), .err_hv(err_hv)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // strobe order: xe ye se oe pg er ms st
    task automatic set_ctl(logic [7:0] s);
        {xen, yen, sen, oen, prg, ers, mass, store} = s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; set_ctl(8'h00); tmode = 1'b1; area_sel = 1'b0;
        row_addr = '0; col_addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_read(logic area, int row, int col, output logic [7:0] val);
        @(negedge clk);
        area_sel = area; row_addr = 10'(row); col_addr = 6'(col);
        set_ctl(8'b1111_0000);
        @(negedge clk);
        val = rdata;
        set_ctl(8'h00);
    endtask

    task automatic do_prog(logic area, int row, int col, logic [7:0] d);
        @(negedge clk);
        area_sel = area; row_addr = 10'(row); col_addr = 6'(col); wdata = d;
        set_ctl(8'b1000_1001);
        @(negedge clk); set_ctl(8'b1100_1001);
        @(negedge clk); set_ctl(8'b1000_1001);
        @(negedge clk); set_ctl(8'h00);
    endtask

    task automatic do_erase(logic area, int row, logic all);
        @(negedge clk);
        area_sel = area; row_addr = 10'(row);
        set_ctl({6'b1000_01, all, 1'b0});
        @(negedge clk); set_ctl({6'b1000_01, all, 1'b1});
        @(negedge clk); set_ctl({6'b1000_01, all, 1'b0});
        @(negedge clk); set_ctl(8'h00);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        check("R1", "rdata after reset", rdata, 8'h00);
        check("R11", "flags after reset", {err_tmode, err_illegal, err_overprog, err_hv}, 0);
        do_read(1'b0, 2, 17, v);
        check("R1", "erased byte main", v, 8'hFF);
        do_read(1'b1, 1, 63, v);
        check("R1", "erased byte info", v, 8'hFF);
    endtask

    task automatic t_program_read();
        logic [7:0] v;
        do_reset();
        do_prog(1'b0, 1, 9, 8'hF0);
        do_read(1'b0, 1, 9, v);
        check("R3", "first program", v, 8'hF0);
        do_prog(1'b0, 1, 9, 8'h3C);
        do_read(1'b0, 1, 9, v);
        check("R3", "second program ANDs", v, 8'h30);
        do_read(1'b0, 5, 9, v);
        check("R1", "row alias 5->1", v, 8'h30);
        do_read(1'b0, 1, 10, v);
        check("R1", "neighbour byte untouched", v, 8'hFF);
        // rdata holds while idle
        repeat (3) @(negedge clk);
        check("R2", "rdata holds when idle", rdata, 8'hFF);
        check("R3", "no flags on legal sequence",
              {err_tmode, err_illegal, err_overprog, err_hv}, 0);
    endtask

    task automatic t_overprog();
        logic [7:0] v;
        do_reset();
        do_prog(1'b0, 0, 4, 8'hF0);
        do_prog(1'b0, 0, 4, 8'h3C);
        check("R9", "no flag after two programs", err_overprog, 0);
        do_prog(1'b0, 0, 4, 8'h00);
        check("R9", "flag on third program", err_overprog, 1);
        do_read(1'b0, 0, 4, v);
        check("R9", "third program ignored", v, 8'h30);
        do_erase(1'b0, 0, 1'b0);
        do_read(1'b0, 0, 4, v);
        check("R4", "page erase sets FF", v, 8'hFF);
        do_prog(1'b0, 0, 4, 8'h0F);
        do_read(1'b0, 0, 4, v);
        check("R4", "program allowed after erase", v, 8'h0F);
        check("R11", "overprog flag sticky", err_overprog, 1);
    endtask

    task automatic t_area_and_mass();
        logic [7:0] v;
        do_reset();
        do_prog(1'b1, 1, 7, 8'hA5);
        do_prog(1'b0, 2, 7, 8'h5A);
        do_read(1'b0, 1, 7, v);
        check("R6", "main row untouched by info program", v, 8'hFF);
        do_read(1'b1, 3, 7, v);
        check("R6", "info row alias 3->1", v, 8'hA5);
        do_erase(1'b0, 0, 1'b1);
        do_read(1'b0, 2, 7, v);
        check("R5", "mass erase main only clears main", v, 8'hFF);
        do_read(1'b1, 1, 7, v);
        check("R5", "mass erase main only keeps info", v, 8'hA5);
        do_erase(1'b1, 0, 1'b1);
        do_read(1'b1, 1, 7, v);
        check("R5", "mass erase with area clears info", v, 8'hFF);
    endtask

    task automatic t_tmode_illegal();
        logic [7:0] v;
        do_reset();
        tmode = 1'b0;
        do_prog(1'b0, 3, 3, 8'h00);
        tmode = 1'b1;
        check("R7", "tmode flag", err_tmode, 1);
        do_read(1'b0, 3, 3, v);
        check("R7", "no program without tmode", v, 8'hFF);
        check("R8", "no illegal flag yet", err_illegal, 0);
        @(negedge clk);
        row_addr = 10'd3; col_addr = 6'd3; wdata = 8'h00; area_sel = 1'b0;
        set_ctl(8'b1100_1101);
        @(negedge clk); set_ctl(8'h00);
        check("R8", "illegal flag on prog+erase", err_illegal, 1);
        do_read(1'b0, 3, 3, v);
        check("R8", "illegal pattern has no effect", v, 8'hFF);
        check("R11", "tmode flag sticky", err_tmode, 1);
    endtask

    task automatic t_hv_budget();
        do_reset();
        @(negedge clk);
        area_sel = 1'b0; row_addr = 10'd2; set_ctl(8'b1000_1001);
        repeat (120) @(negedge clk);
        check("R10", "no flag at budget", err_hv, 0);
        @(negedge clk);
        set_ctl(8'h00);
        check("R10", "flag one cycle beyond budget", err_hv, 1);

        do_reset();
        @(negedge clk);
        row_addr = 10'd3; set_ctl(8'b1000_1001);
        repeat (100) @(negedge clk);
        set_ctl(8'h00);
        do_erase(1'b0, 3, 1'b0);
        @(negedge clk);
        row_addr = 10'd3; set_ctl(8'b1000_1001);
        repeat (100) @(negedge clk);
        check("R4", "erase restarts row budget", err_hv, 0);
        repeat (21) @(negedge clk);
        set_ctl(8'h00);
        check("R10", "flag after 121 cycles post erase", err_hv, 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; tmode = 1'b1; area_sel = 1'b0;
        row_addr = '0; col_addr = '0; wdata = '0;
        set_ctl(8'h00);
        t_reset_state();
        t_program_read();
        t_overprog();
        t_area_and_mass();
        t_tmode_illegal();
        t_hv_budget();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule